// File: doc/BRIEF.md
# USB Host Controller Status and Interrupt Register

This block holds the status word of a host controller that walks a frame list. The schedule engine and the system-bus interface report events to it as single-cycle pulses: descriptor completions with their qualifiers, descriptor consistency failures, bus faults and device resume signalling. The block latches each event into a sticky status bit. Software reads the bits and clears them by writing 1. It also drives one level interrupt, which an enable vector gates.

The block also owns the Run/Stop control bit. Software sets and clears Run/Stop. A fatal fault forces it low on its own. A halted flag records when execution has really drained after a stop. A start-of-frame tick counter restarts from zero on a stop, so the next run begins a fresh frame instead of resuming partway through one. When debug mode is active, a stop leaves that counter where it was.

Top module: `hc_status_regs`

## Requirements
- R1: During and straight after reset, `status` is 0000h, `run_stop` is 0, `irq` is 0 and `sof_cnt` is 0. Status bits 15:6 always read 0, and writing to them has no effect.
- R2: A status write with `sw_wr_en` clears each defined bit whose data bit is 1. Bits written with 0 keep their value.
- R3: When a hardware set and a software clear reach the same bit in the same cycle, the bit ends up 1.
- R4: When `run_stop` is 0 and `xact_active` is low at a clock edge, bit 5 (halted) reads 1 after that edge. While `xact_active` stays high, halted stays 0. A software write of Run/Stop = 1 sets `run_stop` and clears halted at the next edge.
- R5: `ev_pid_err` sets bit 4 (process error) and forces `run_stop` to 0 at the next edge.
- R6: Any bit of `sys_err` (parity, master abort, target abort) sets bit 3 (system error) and forces `run_stop` to 0 at the next edge.
- R7: `ev_resume` sets bit 2 only while `global_suspend` is 1. At other times it leaves status unchanged.
- R8: `ev_done` with `desc_err` sets bit 1. If `desc_ioc` is also set, bits 1 and 0 are both set at the same edge.
- R9: `ev_done` sets bit 0 when `desc_ioc` is set, or when both `desc_short` and `desc_spd` are set. Qualifiers given without `ev_done` have no effect.
- R10: `irq` is high when any of these holds: bit 0 is set with `irq_en[0]`, bit 1 is set with `irq_en[1]`, bit 2 is set with `irq_en[2]`, or bit 3 or bit 4 is set (these need no enable). Halted never raises `irq`.
- R11: A fatal event and a software Run/Stop = 1 write in the same cycle leave `run_stop` at 0.
- R12: `sof_cnt` advances by one on each `sof_tick` while `run_stop` is 1. It wraps from FRAME_TICKS-1 to 0, and it holds while `run_stop` is 0.
- R13: When `run_stop` falls with `debug_mode` low, `sof_cnt` reads 0 at that same edge. With `debug_mode` high it keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_wr_en | input | 1 | Software write strobe for the status word |
| sw_wr_data | input | 16 | Write-1-to-clear mask |
| cmd_wr_en | input | 1 | Software write strobe for Run/Stop |
| cmd_run | input | 1 | Run/Stop value written |
| debug_mode | input | 1 | Debug mode: a stop keeps the frame counter |
| global_suspend | input | 1 | Command-register global suspend bit |
| xact_active | input | 1 | A bus transaction is in progress |
| ev_done | input | 1 | Descriptor completion pulse |
| desc_ioc | input | 1 | Completed descriptor requested an interrupt |
| desc_err | input | 1 | Completion ended in error |
| desc_short | input | 1 | Actual length below maximum length |
| desc_spd | input | 1 | Short packet detection enabled in descriptor |
| ev_resume | input | 1 | Resume signalling seen from a device |
| ev_pid_err | input | 1 | Descriptor consistency failure pulse |
| sys_err | input | 3 | Parity, master abort, target abort pulses |
| sof_tick | input | 1 | Bit-time tick for the frame counter |
| irq_en | input | 3 | Enables for status bits 2:0 |
| status | output | 16 | Status word |
| run_stop | output | 1 | Run/Stop control bit |
| irq | output | 1 | Level interrupt |
| sof_cnt | output | $clog2(FRAME_TICKS) | Position inside the current frame |

## Verification
The properties assume that event inputs are single-cycle pulses sampled at the rising edge, and that `xact_active` is a level owned by the schedule engine. They also assume qualifier inputs carry meaning only in a cycle where `ev_done` is high. The bench drives every input at the falling edge and holds each event pulse for exactly one cycle. It keeps `xact_active` high through the vector walk, so halted changes only in the directed drain test. It keeps `sof_tick` low in cycles where Run/Stop changes, so counting and rewinding never coincide.

// File: rtl/hcs_pkg.sv
package hcs_pkg;

    localparam int STAT_W    = 16;
    localparam int DEF_W     = 6;
    localparam int IRQ_EN_W  = 3;
    localparam int SYS_ERR_W = 3;

    localparam int B_USBINT  = 0;
    localparam int B_ERRINT  = 1;
    localparam int B_RESUME  = 2;
    localparam int B_SYSERR  = 3;
    localparam int B_PROCERR = 4;
    localparam int B_HALT    = 5;

    // Packed MSB first, so the field order matches status bits 5..0.
    typedef struct packed {
        logic halt;
        logic proc_err;
        logic sys_err;
        logic resume;
        logic err_int;
        logic usb_int;
    } hcs_bits_t;

    typedef struct packed {
        logic done;
        logic ioc;
        logic err;
        logic short_pkt;
        logic spd;
    } hcs_desc_evt_t;

    typedef enum logic [1:0] {
        RUN_HOLD,
        RUN_START,
        RUN_SW_STOP,
        RUN_FATAL_STOP
    } run_cmd_e;

    function automatic hcs_bits_t hcs_event_sets(
        input hcs_desc_evt_t d,
        input logic          resume_ev,
        input logic          suspended,
        input logic          pid_err,
        input logic          bus_err,
        input logic          halt_cond
    );
        hcs_bits_t s;
        s.usb_int  = d.done & (d.ioc | (d.short_pkt & d.spd));
        s.err_int  = d.done & d.err;
        s.resume   = resume_ev & suspended;
        s.sys_err  = bus_err;
        s.proc_err = pid_err;
        s.halt     = halt_cond;
        return s;
    endfunction

    // Fatal faults outrank any software write of Run/Stop.
    function automatic run_cmd_e hcs_run_decide(
        input logic fatal,
        input logic wr,
        input logic run_val
    );
        if (fatal)
            return RUN_FATAL_STOP;
        else if (wr && run_val)
            return RUN_START;
        else if (wr)
            return RUN_SW_STOP;
        else
            return RUN_HOLD;
    endfunction

endpackage

// File: rtl/hcs_run_ctrl.sv
module hcs_run_ctrl
    import hcs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cmd_wr,
    input  logic cmd_run,
    input  logic fatal,
    output logic run_stop,
    output logic run_start,
    output logic run_fall
);

    run_cmd_e act;

    assign act = hcs_run_decide(fatal, cmd_wr, cmd_run);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_stop <= 1'b0;
        end else begin
            case (act)
                RUN_START:      run_stop <= 1'b1;
                RUN_SW_STOP:    run_stop <= 1'b0;
                RUN_FATAL_STOP: run_stop <= 1'b0;
                default:        run_stop <= run_stop;
            endcase
        end
    end

    assign run_start = (act == RUN_START);
    assign run_fall  = run_stop && ((act == RUN_SW_STOP) || (act == RUN_FATAL_STOP));

endmodule

// File: rtl/hcs_sticky.sv
module hcs_sticky #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set,
    input  logic [W-1:0] clr,
    input  logic [W-1:0] kill,
    output logic [W-1:0] q
);

    // Per bit: kill > set > software clear > hold.
    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                q[i] <= 1'b0;
            else if (kill[i])
                q[i] <= 1'b0;
            else if (set[i])
                q[i] <= 1'b1;
            else if (clr[i])
                q[i] <= 1'b0;
        end
    end

endmodule

// File: rtl/hcs_sof_counter.sv
module hcs_sof_counter #(
    parameter int FRAME_TICKS = 12000,
    parameter int CNT_W       = $clog2(FRAME_TICKS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             running,
    input  logic             tick,
    input  logic             rewind,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_TICKS - 1);

    always_ff @(posedge clk) begin
        if (rst || rewind)
            cnt <= '0;
        else if (running && tick)
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end

endmodule

// File: rtl/hcs_irq_gate.sv
module hcs_irq_gate
    import hcs_pkg::*;
(
    input  hcs_bits_t             st,
    input  logic [IRQ_EN_W-1:0]   en,
    output logic                  irq
);

    logic [IRQ_EN_W-1:0] maskable;

    assign maskable = {st.resume, st.err_int, st.usb_int} & en;
    assign irq      = (|maskable) | st.sys_err | st.proc_err;

endmodule

// File: rtl/hc_status_regs.sv
module hc_status_regs
    import hcs_pkg::*;
#(
    parameter int  FRAME_TICKS = 12000,
    localparam int CNT_W       = $clog2(FRAME_TICKS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sw_wr_en,
    input  logic [STAT_W-1:0]    sw_wr_data,
    input  logic                 cmd_wr_en,
    input  logic                 cmd_run,
    input  logic                 debug_mode,
    input  logic                 global_suspend,
    input  logic                 xact_active,
    input  logic                 ev_done,
    input  logic                 desc_ioc,
    input  logic                 desc_err,
    input  logic                 desc_short,
    input  logic                 desc_spd,
    input  logic                 ev_resume,
    input  logic                 ev_pid_err,
    input  logic [SYS_ERR_W-1:0] sys_err,
    input  logic                 sof_tick,
    input  logic [IRQ_EN_W-1:0]  irq_en,
    output logic [STAT_W-1:0]    status,
    output logic                 run_stop,
    output logic                 irq,
    output logic [CNT_W-1:0]     sof_cnt
);

    hcs_desc_evt_t    dev;
    hcs_bits_t        sets;
    hcs_bits_t        st;
    logic [DEF_W-1:0] set_vec;
    logic [DEF_W-1:0] clr_vec;
    logic [DEF_W-1:0] kill_vec;
    logic [DEF_W-1:0] bits_q;
    logic             fatal;
    logic             bus_err;
    logic             run_start;
    logic             run_fall;
    logic             halt_cond;
    logic             unused_hi;

    assign unused_hi = ^sw_wr_data[STAT_W-1:DEF_W];

    assign bus_err   = |sys_err;
    assign fatal     = ev_pid_err | bus_err;
    assign halt_cond = !run_stop && !xact_active;
    assign dev       = {ev_done, desc_ioc, desc_err, desc_short, desc_spd};

    assign sets    = hcs_event_sets(dev, ev_resume, global_suspend,
                                    ev_pid_err, bus_err, halt_cond);
    assign set_vec = sets;
    assign clr_vec = sw_wr_en ? sw_wr_data[DEF_W-1:0] : '0;

    always_comb begin
        kill_vec         = '0;
        kill_vec[B_HALT] = run_start;
    end

    hcs_run_ctrl u_run (
        .clk       (clk),
        .rst       (rst),
        .cmd_wr    (cmd_wr_en),
        .cmd_run   (cmd_run),
        .fatal     (fatal),
        .run_stop  (run_stop),
        .run_start (run_start),
        .run_fall  (run_fall)
    );

    hcs_sticky #(.W(DEF_W)) u_bits (
        .clk  (clk),
        .rst  (rst),
        .set  (set_vec),
        .clr  (clr_vec),
        .kill (kill_vec),
        .q    (bits_q)
    );

    assign st     = bits_q;
    assign status = {{(STAT_W-DEF_W){1'b0}}, bits_q};

    hcs_irq_gate u_irq (
        .st  (st),
        .en  (irq_en),
        .irq (irq)
    );

    hcs_sof_counter #(.FRAME_TICKS(FRAME_TICKS), .CNT_W(CNT_W)) u_sof (
        .clk     (clk),
        .rst     (rst),
        .running (run_stop),
        .tick    (sof_tick),
        .rewind  (run_fall && !debug_mode),
        .cnt     (sof_cnt)
    );

endmodule

// File: rtl/hcs_checker.sv
module hcs_checker #(
    parameter int FRAME_TICKS = 12000,
    parameter int CNT_W       = $clog2(FRAME_TICKS)
) (
    input logic             clk,
    input logic             rst,
    input logic             sw_wr_en,
    input logic [15:0]      sw_wr_data,
    input logic             cmd_wr_en,
    input logic             cmd_run,
    input logic             debug_mode,
    input logic             global_suspend,
    input logic             xact_active,
    input logic             ev_done,
    input logic             desc_ioc,
    input logic             desc_err,
    input logic             desc_short,
    input logic             desc_spd,
    input logic             ev_resume,
    input logic             ev_pid_err,
    input logic [2:0]       sys_err,
    input logic [15:0]      status,
    input logic             run_stop,
    input logic             irq,
    input logic [CNT_W-1:0] sof_cnt
);

    p_reserved_zero_r1: assert property (@(posedge clk) disable iff (rst)
        status[15:6] == 10'd0);

    p_w1c_r2: assert property (@(posedge clk) disable iff (rst)
        (sw_wr_en && sw_wr_data[1] && !(ev_done && desc_err)) |=> !status[1]);

    p_set_wins_r3: assert property (@(posedge clk) disable iff (rst)
        (ev_done && desc_ioc) |=> status[0]);

    p_halt_set_r4: assert property (@(posedge clk) disable iff (rst)
        (!run_stop && !xact_active && !(cmd_wr_en && cmd_run)) |=> status[5]);

    p_start_r4: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr_en && cmd_run && !ev_pid_err && (sys_err == 3'd0))
            |=> (run_stop && !status[5]));

    p_pid_stop_r5: assert property (@(posedge clk) disable iff (rst)
        ev_pid_err |=> (status[4] && !run_stop));

    p_bus_stop_r6: assert property (@(posedge clk) disable iff (rst)
        (sys_err != 3'd0) |=> (status[3] && !run_stop));

    p_resume_gate_r7: assert property (@(posedge clk) disable iff (rst)
        (!status[2] && !(ev_resume && global_suspend)) |=> !status[2]);

    p_err_ioc_r8: assert property (@(posedge clk) disable iff (rst)
        (ev_done && desc_err && desc_ioc) |=> (status[1:0] == 2'b11));

    p_short_r9: assert property (@(posedge clk) disable iff (rst)
        (ev_done && desc_short && desc_spd) |=> status[0]);

    p_fatal_irq_r10: assert property (@(posedge clk) disable iff (rst)
        (status[3] || status[4]) |-> irq);

    p_quiet_irq_r10: assert property (@(posedge clk) disable iff (rst)
        (status[4:0] == 5'd0) |-> !irq);

    p_sof_hold_r12: assert property (@(posedge clk) disable iff (rst)
        !run_stop |=> $stable(sof_cnt));

    p_sof_rewind_r13: assert property (@(posedge clk) disable iff (rst)
        (run_stop && !debug_mode &&
         ((cmd_wr_en && !cmd_run) || ev_pid_err || (sys_err != 3'd0)))
            |=> (sof_cnt == '0));

endmodule

bind hc_status_regs hcs_checker #(.FRAME_TICKS(FRAME_TICKS)) u_hcs_chk (
    .clk            (clk),
    .rst            (rst),
    .sw_wr_en       (sw_wr_en),
    .sw_wr_data     (sw_wr_data),
    .cmd_wr_en      (cmd_wr_en),
    .cmd_run        (cmd_run),
    .debug_mode     (debug_mode),
    .global_suspend (global_suspend),
    .xact_active    (xact_active),
    .ev_done        (ev_done),
    .desc_ioc       (desc_ioc),
    .desc_err       (desc_err),
    .desc_short     (desc_short),
    .desc_spd       (desc_spd),
    .ev_resume      (ev_resume),
    .ev_pid_err     (ev_pid_err),
    .sys_err        (sys_err),
    .status         (status),
    .run_stop       (run_stop),
    .irq            (irq),
    .sof_cnt        (sof_cnt)
);

// File: tb/hc_status_regs_bench.sv
module hc_status_regs_bench;

    localparam int CLK_PERIOD = 10;
    localparam int FT         = 16;
    localparam int CW         = $clog2(FT);
    localparam int NVEC       = 13;

    // Fields: [18:16] sys_err, [15] pid, [14] resume, [13] suspend, [12] done,
    // [11] ioc, [10] err, [9] short, [8] spd, [7:2] status[5:0], [1] run, [0] irq
    localparam logic [18:0] VEC [NVEC] = '{
        19'b000_0_0_0_1_1_0_0_0_000001_1_1,  // R9 ioc
        19'b000_0_0_0_1_0_1_0_0_000010_1_1,  // R8 error
        19'b000_0_0_0_1_1_1_0_0_000011_1_1,  // R8 error with ioc
        19'b000_0_0_0_1_0_0_1_1_000001_1_1,  // R9 short with detect
        19'b000_0_0_0_1_0_0_1_0_000000_1_0,  // R9 short without detect
        19'b000_0_0_0_0_1_1_1_1_000000_1_0,  // R9 qualifiers without done
        19'b000_0_1_1_0_0_0_0_0_000100_1_1,  // R7 resume in suspend
        19'b000_0_1_0_0_0_0_0_0_000000_1_0,  // R7 resume ignored
        19'b001_0_0_0_0_0_0_0_0_001000_0_1,  // R6 parity
        19'b010_0_0_0_0_0_0_0_0_001000_0_1,  // R6 master abort
        19'b100_0_0_0_0_0_0_0_0_001000_0_1,  // R6 target abort
        19'b000_1_0_0_0_0_0_0_0_010000_0_1,  // R5 pid error
        19'b000_1_0_0_1_1_0_0_0_010001_0_1   // R5 pid with ioc completion
    };

    logic          clk = 1'b0;
    logic          rst;
    logic          sw_wr_en, cmd_wr_en, cmd_run, debug_mode, global_suspend;
    logic [15:0]   sw_wr_data;
    logic          xact_active, ev_done, desc_ioc, desc_err, desc_short, desc_spd;
    logic          ev_resume, ev_pid_err, sof_tick;
    logic [2:0]    sys_err, irq_en;
    logic [15:0]   status;
    logic          run_stop, irq;
    logic [CW-1:0] sof_cnt;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hc_status_regs #(.FRAME_TICKS(FT)) u_hc_status_regs (
        .clk(clk), .rst(rst), .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data),
        .cmd_wr_en(cmd_wr_en), .cmd_run(cmd_run), .debug_mode(debug_mode),
        .global_suspend(global_suspend), .xact_active(xact_active),
        .ev_done(ev_done), .desc_ioc(desc_ioc), .desc_err(desc_err),
        .desc_short(desc_short), .desc_spd(desc_spd), .ev_resume(ev_resume),
        .ev_pid_err(ev_pid_err), .sys_err(sys_err), .sof_tick(sof_tick),
        .irq_en(irq_en), .status(status), .run_stop(run_stop), .irq(irq),
        .sof_cnt(sof_cnt)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic quiet();
        sw_wr_en = 0; sw_wr_data = '0; cmd_wr_en = 0; cmd_run = 0;
        ev_done = 0; desc_ioc = 0; desc_err = 0; desc_short = 0; desc_spd = 0;
        ev_resume = 0; ev_pid_err = 0; sys_err = '0; sof_tick = 0;
    endtask

    task automatic clear_and_start();
        sw_wr_en = 1; sw_wr_data = 16'hFFFF; cmd_wr_en = 1; cmd_run = 1;
        cyc();
        quiet();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        quiet();
        rst = 1; debug_mode = 0; global_suspend = 0; xact_active = 0; irq_en = '0;
        @(negedge clk);
        cyc();
        check("R1 reset status", 32'(status), 32'h0);
        check("R1 reset run", 32'(run_stop), 0);
        check("R1 reset irq", 32'(irq), 0);
        check("R1 reset sof", 32'(sof_cnt), 0);
        rst = 0;
        cyc();
        check("R4 halted when idle and stopped", 32'(status), 32'h0020);
        irq_en = 3'b111;
        check("R10 halted gives no irq", 32'(irq), 0);

        // Vector walk: transaction always in progress.
        xact_active = 1;
        for (int i = 0; i < NVEC; i++) begin
            clear_and_start();
            sys_err = VEC[i][18:16]; ev_pid_err = VEC[i][15];
            ev_resume = VEC[i][14]; global_suspend = VEC[i][13];
            ev_done = VEC[i][12]; desc_ioc = VEC[i][11]; desc_err = VEC[i][10];
            desc_short = VEC[i][9]; desc_spd = VEC[i][8];
            cyc();
            quiet();
            global_suspend = 0;
            check($sformatf("R5-vector %0d status (R1 R5 R6 R7 R8 R9)", i),
                  32'(status), {26'd0, VEC[i][7:2]});
            check($sformatf("vector %0d run R5 R6", i), 32'(run_stop), 32'(VEC[i][1]));
            check($sformatf("vector %0d irq R10", i), 32'(irq), 32'(VEC[i][0]));
        end

        // R2 write-1-to-clear
        clear_and_start();
        ev_done = 1; desc_ioc = 1; cyc(); quiet();
        sw_wr_en = 1; sw_wr_data = 16'h0000; cyc(); quiet();
        check("R2 write zero keeps bit", 32'(status[0]), 1);
        sw_wr_en = 1; sw_wr_data = 16'h0002; cyc(); quiet();
        check("R2 other bit write keeps bit", 32'(status[0]), 1);
        sw_wr_en = 1; sw_wr_data = 16'h0001; cyc(); quiet();
        check("R2 write one clears", 32'(status[0]), 0);

        // R3 set beats clear
        ev_done = 1; desc_ioc = 1; sw_wr_en = 1; sw_wr_data = 16'h0001; cyc(); quiet();
        check("R3 set wins", 32'(status[0]), 1);

        // R10 gating
        irq_en = 3'b000; #1;
        check("R10 masked usb int", 32'(irq), 0);
        irq_en = 3'b001; #1;
        check("R10 enabled usb int", 32'(irq), 1);
        irq_en = 3'b111;
        sw_wr_en = 1; sw_wr_data = 16'h003F; cyc(); quiet();

        // R4 drain then halt
        cmd_wr_en = 1; cmd_run = 0; cyc(); quiet();
        check("R4 stopped", 32'(run_stop), 0);
        check("R4 not halted while busy", 32'(status[5]), 0);
        cyc();
        check("R4 still not halted", 32'(status[5]), 0);
        xact_active = 0; cyc();
        check("R4 halted after drain", 32'(status[5]), 1);
        check("R10 halted no irq", 32'(irq), 0);
        cmd_wr_en = 1; cmd_run = 1; cyc(); quiet();
        check("R4 start clears halted", 32'(status[5]), 0);
        check("R4 start runs", 32'(run_stop), 1);
        xact_active = 1;

        // R11 fatal beats software start
        ev_pid_err = 1; cmd_wr_en = 1; cmd_run = 1; cyc(); quiet();
        check("R11 fatal wins", 32'(run_stop), 0);
        irq_en = 3'b000; #1;
        check("R10 fatal irq without enable", 32'(irq), 1);
        irq_en = 3'b111;

        // R12/R13 frame counter
        clear_and_start();
        check("R12 counter idle", 32'(sof_cnt), 0);
        sof_tick = 1; repeat (5) cyc(); sof_tick = 0;
        check("R12 counts ticks", 32'(sof_cnt), 5);
        cmd_wr_en = 1; cmd_run = 0; cyc(); quiet();
        check("R13 stop rewinds", 32'(sof_cnt), 0);
        cmd_wr_en = 1; cmd_run = 1; cyc(); quiet();
        sof_tick = 1; repeat (5) cyc(); sof_tick = 0;
        debug_mode = 1; cmd_wr_en = 1; cmd_run = 0; cyc(); quiet();
        check("R13 debug stop holds", 32'(sof_cnt), 5);
        sof_tick = 1; repeat (2) cyc(); sof_tick = 0;
        check("R12 no count when stopped", 32'(sof_cnt), 5);
        debug_mode = 0; cmd_wr_en = 1; cmd_run = 1; cyc(); quiet();
        sof_tick = 1; repeat (11) cyc(); sof_tick = 0;
        check("R12 wrap to zero", 32'(sof_cnt), 0);
        sof_tick = 1; cyc(); sof_tick = 0;
        check("R12 count after wrap", 32'(sof_cnt), 1);
        check("R1 reserved bits zero", 32'(status[15:6]), 0);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule